// File: doc/BRIEF.md
# Parallel Radix FFT Stage with Selectable Word Growth

This block is one pipelined stage of a parallel fixed-point FFT. On every clock where `in_valid` is high it accepts `RADIX` complex samples, one per lane. Each lane is first multiplied by a twiddle factor taken from a table computed at elaboration. The rotated lanes then pass through a radix-`RADIX` butterfly. One cycle after that, `RADIX` complex results leave on the output lanes together with `out_valid`. A full transform of length `FFT_LEN` chains log_RADIX(FFT_LEN) copies of this stage, each with its own `STAGE_IDX`. The reordering of data between stages is done outside the block.

Three compile-time parameters shape the arithmetic:
- `GROWTH` sets the output word width.
  - `GROW_FREE` (encoding 0) adds log2(RADIX) bits to the width.
  - `SCALE_EACH` (encoding 1) keeps the input width and divides the result down.
  - `GROW_CAPPED` (encoding 2) grows the width while the result stays within 27 bits, and scales once the grown width would pass 27.
- `INVERSE` flips the sign of every exponent, for both the twiddles and the butterfly kernel.
- `STAGE_IDX` picks which twiddle set the stage applies.

Top module: `fft_radix_stage`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock cycles. The result of a beat appears in the same cycle as that beat's delayed valid.
- R2: A beat counter counts accepted beats modulo FFT_LEN/RADIX. Call its value g for the current beat. Lane r is multiplied by W = exp(-j·2π·e/FFT_LEN), with e = (r · (g mod RADIX^STAGE_IDX) · FFT_LEN/RADIX^(STAGE_IDX+1)) mod FFT_LEN. Each twiddle component is stored as an 18-bit signed value with 16 fraction bits, rounded to nearest with halves away from zero.
- R3: For lane input x and twiddle w, each part of the product (the real part x_re·w_re − x_im·w_im and the imaginary part x_re·w_im + x_im·w_re) is computed exactly and then truncated toward minus infinity by 16 bits.
- R4: Output lane k equals the sum over r of y_r·exp(-j·2π·r·k/RADIX), where y_r is the lane r product. Lane k sits at bits [k·OUT_W +: OUT_W] of each output bus, and lane r of the input sits at bits [r·DATA_W +: DATA_W]. RADIX is 2 or 4.
- R5: With INVERSE = 1, the exponent sign in R2 and in R4 becomes positive.
- R6: In GROW_FREE, OUT_W = DATA_W + log2(RADIX) and the butterfly sum is not shifted.
- R7: In SCALE_EACH, OUT_W = DATA_W and the butterfly sum is arithmetically shifted right by log2(RADIX).
- R8: In GROW_CAPPED, the stage behaves as GROW_FREE when DATA_W + log2(RADIX) ≤ 27, and as SCALE_EACH otherwise.
- R9: A result outside the signed OUT_W range is clamped to the nearest end of that range.
- R10: While in_valid is low, the beat counter does not advance and the input data is ignored. In a cycle where out_valid is low, the output buses keep their last value.
- R11: While rst_n is low, out_valid is 0 and the beat counter is cleared, so the first beat after reset uses g = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input lanes carry a beat |
| in_re | input | RADIX*DATA_W | Real parts of the input lanes, lane r at [r*DATA_W +: DATA_W] |
| in_im | input | RADIX*DATA_W | Imaginary parts of the input lanes |
| out_valid | output | 1 | Output lanes carry a result |
| out_re | output | RADIX*OUT_W | Real parts of the output lanes, lane k at [k*OUT_W +: OUT_W] |
| out_im | output | RADIX*OUT_W | Imaginary parts of the output lanes |

## Verification
The beat counter is the only state that spans beats. If it is wrong, every stage with STAGE_IDX above zero applies the wrong twiddle on lanes 1 and up, and the error shows on the output lanes two cycles after the beat. Idle cycles and a reset in the middle of a frame are placed so that a counter that slips or fails to clear is caught on the next valid beat. A broken valid pipeline shows at once as a result in the wrong cycle. Errors in rounding, rotation or scaling show as a miscompare on the affected lane. Full-scale inputs drive the clamp on both signs.

// File: rtl/fftst_pkg.sv
package fftst_pkg;

  typedef enum logic [1:0] {
    GROW_FREE   = 2'd0,
    SCALE_EACH  = 2'd1,
    GROW_CAPPED = 2'd2
  } growth_e;

  localparam int TW_W    = 18;
  localparam int TW_FRAC = 16;
  localparam int CAP_W   = 27;
  localparam real PI_R   = 3.14159265358979323846;

  function automatic bit does_scale(int dw, int lg, growth_e m);
    case (m)
      GROW_FREE:  return 1'b0;
      SCALE_EACH: return 1'b1;
      default:    return (dw + lg > CAP_W);
    endcase
  endfunction

  function automatic int out_width(int dw, int lg, growth_e m);
    return does_scale(dw, lg, m) ? dw : dw + lg;
  endfunction

  function automatic int tw_quant(real x);
    if (x >= 0.0) return $rtoi(x * 65536.0 + 0.5);
    else          return -$rtoi(-x * 65536.0 + 0.5);
  endfunction

  function automatic logic signed [TW_W-1:0] tw_real(int e, int len);
    return TW_W'(tw_quant($cos(2.0 * PI_R * e / len)));
  endfunction

  function automatic logic signed [TW_W-1:0] tw_imag(int e, int len, bit inv);
    real s;
    s = $sin(2.0 * PI_R * e / len);
    return TW_W'(tw_quant(inv ? s : -s));
  endfunction

endpackage

// File: rtl/fftst_twiddle.sv
module fftst_twiddle #(
  parameter int RADIX     = 4,
  parameter int FFT_LEN   = 16,
  parameter int STAGE_IDX = 0,
  parameter bit INVERSE   = 1'b0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  adv,
  output logic [RADIX*fftst_pkg::TW_W-1:0]      tw_re,
  output logic [RADIX*fftst_pkg::TW_W-1:0]      tw_im
);
  import fftst_pkg::*;

  localparam int LOG2L   = $clog2(FFT_LEN);
  localparam int BEATS   = FFT_LEN / RADIX;
  localparam int BW      = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int SPAN_IN = RADIX ** STAGE_IDX;
  localparam int STRIDE  = FFT_LEN / (RADIX ** (STAGE_IDX + 1));
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  logic [BW-1:0] beat_q, beat_d;

  always_comb begin
    beat_d = beat_q;
    if (adv) begin
      if (beat_q == LAST_BEAT) beat_d = '0;
      else                     beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  logic signed [TW_W-1:0] cos_tab [FFT_LEN];
  logic signed [TW_W-1:0] sin_tab [FFT_LEN];

  for (genvar e = 0; e < FFT_LEN; e++) begin : g_tab
    localparam logic signed [TW_W-1:0] CV = tw_real(e, FFT_LEN);
    localparam logic signed [TW_W-1:0] SV = tw_imag(e, FFT_LEN, INVERSE);
    assign cos_tab[e] = CV;
    assign sin_tab[e] = SV;
  end

  logic [LOG2L-1:0] local_idx;
  assign local_idx = LOG2L'(beat_q) & LOG2L'(SPAN_IN - 1);

  for (genvar r = 0; r < RADIX; r++) begin : g_lane
    logic [LOG2L-1:0] expo;
    assign expo = LOG2L'(r * STRIDE) * local_idx;
    assign tw_re[r*TW_W +: TW_W] = cos_tab[expo];
    assign tw_im[r*TW_W +: TW_W] = sin_tab[expo];
  end

  assert_beat_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && beat_q == LAST_BEAT) |=> (beat_q == '0));
  assert_beat_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && beat_q != LAST_BEAT) |=> (beat_q == $past(beat_q) + 1'b1));
  assert_beat_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(beat_q));

endmodule

// File: rtl/fftst_cmul.sv
module fftst_cmul #(
  parameter int DATA_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                en,
  input  logic signed [DATA_W-1:0]            a_re,
  input  logic signed [DATA_W-1:0]            a_im,
  input  logic signed [fftst_pkg::TW_W-1:0]   w_re,
  input  logic signed [fftst_pkg::TW_W-1:0]   w_im,
  output logic signed [DATA_W+1:0]            y_re,
  output logic signed [DATA_W+1:0]            y_im
);
  import fftst_pkg::*;

  localparam int PW = DATA_W + TW_W;
  localparam int YW = DATA_W + 2;

  logic signed [PW-1:0] p_re, p_im;
  logic signed [YW-1:0] y_re_d, y_im_d;

  always_comb begin
    p_re   = PW'(a_re) * PW'(w_re) - PW'(a_im) * PW'(w_im);
    p_im   = PW'(a_re) * PW'(w_im) + PW'(a_im) * PW'(w_re);
    y_re_d = YW'(p_re >>> TW_FRAC);
    y_im_d = YW'(p_im >>> TW_FRAC);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      y_re <= y_re_d;
      y_im <= y_im_d;
    end
  end

  assert_prod_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(y_re) && $stable(y_im)));

endmodule

// File: rtl/fftst_butterfly.sv
module fftst_butterfly #(
  parameter int RADIX    = 4,
  parameter int IN_W     = 18,
  parameter int OUT_W    = 18,
  parameter bit DO_SCALE = 1'b0,
  parameter bit INVERSE  = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [RADIX*IN_W-1:0]   y_re,
  input  logic [RADIX*IN_W-1:0]   y_im,
  output logic [RADIX*OUT_W-1:0]  z_re,
  output logic [RADIX*OUT_W-1:0]  z_im
);
  localparam int LOG2R = $clog2(RADIX);
  localparam int SUM_W = IN_W + 1 + LOG2R;
  localparam int QSTEP = 4 / RADIX;
  localparam logic signed [SUM_W-1:0] HI =
    {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO =
    {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  function automatic logic signed [OUT_W-1:0] clamp(logic signed [SUM_W-1:0] v);
    if (v > HI)      return OUT_W'(HI);
    else if (v < LO) return OUT_W'(LO);
    else             return OUT_W'(v);
  endfunction

  for (genvar k = 0; k < RADIX; k++) begin : g_out
    logic signed [SUM_W-1:0] acc_re, acc_im, sh_re, sh_im;
    logic signed [OUT_W-1:0] z_re_d, z_im_d;

    always_comb begin
      logic signed [IN_W-1:0]  lr, li;
      logic signed [SUM_W-1:0] a, b;
      int q;
      acc_re = '0;
      acc_im = '0;
      for (int r = 0; r < RADIX; r++) begin
        lr = y_re[r*IN_W +: IN_W];
        li = y_im[r*IN_W +: IN_W];
        a  = SUM_W'(lr);
        b  = SUM_W'(li);
        q  = (QSTEP * r * k) % 4;
        if (INVERSE) q = (4 - q) % 4;
        case (q)
          0: begin acc_re = acc_re + a; acc_im = acc_im + b; end
          1: begin acc_re = acc_re + b; acc_im = acc_im - a; end
          2: begin acc_re = acc_re - a; acc_im = acc_im - b; end
          default: begin acc_re = acc_re - b; acc_im = acc_im + a; end
        endcase
      end
    end

    if (DO_SCALE) begin : g_scale
      assign sh_re = acc_re >>> LOG2R;
      assign sh_im = acc_im >>> LOG2R;
    end else begin : g_keep
      assign sh_re = acc_re;
      assign sh_im = acc_im;
    end

    assign z_re_d = clamp(sh_re);
    assign z_im_d = clamp(sh_im);

    always_ff @(posedge clk) begin
      if (en) begin
        z_re[k*OUT_W +: OUT_W] <= z_re_d;
        z_im[k*OUT_W +: OUT_W] <= z_im_d;
      end
    end
  end

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(z_re) && $stable(z_im)));

endmodule

// File: rtl/fft_radix_stage.sv
module fft_radix_stage #(
  parameter int                 RADIX     = 4,
  parameter int                 DATA_W    = 16,
  parameter int                 FFT_LEN   = 16,
  parameter int                 STAGE_IDX = 0,
  parameter fftst_pkg::growth_e GROWTH    = fftst_pkg::GROW_FREE,
  parameter bit                 INVERSE   = 1'b0,
  localparam int                OUT_W     =
    fftst_pkg::out_width(DATA_W, $clog2(RADIX), GROWTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [RADIX*DATA_W-1:0] in_re,
  input  logic [RADIX*DATA_W-1:0] in_im,
  output logic                    out_valid,
  output logic [RADIX*OUT_W-1:0]  out_re,
  output logic [RADIX*OUT_W-1:0]  out_im
);
  import fftst_pkg::*;

  localparam int  LOG2R    = $clog2(RADIX);
  localparam int  YW       = DATA_W + 2;
  localparam bit  DO_SCALE = does_scale(DATA_W, LOG2R, GROWTH);

  logic v1_q, v2_q, v1_d, v2_d;

  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  logic [RADIX*TW_W-1:0] tw_re, tw_im;

  fftst_twiddle #(
    .RADIX(RADIX), .FFT_LEN(FFT_LEN), .STAGE_IDX(STAGE_IDX), .INVERSE(INVERSE)
  ) u_tw (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .tw_re(tw_re), .tw_im(tw_im)
  );

  logic [RADIX*YW-1:0] y_re, y_im;

  for (genvar r = 0; r < RADIX; r++) begin : g_mul
    fftst_cmul #(.DATA_W(DATA_W)) u_mul (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (in_valid),
      .a_re (in_re[r*DATA_W +: DATA_W]),
      .a_im (in_im[r*DATA_W +: DATA_W]),
      .w_re (tw_re[r*TW_W +: TW_W]),
      .w_im (tw_im[r*TW_W +: TW_W]),
      .y_re (y_re[r*YW +: YW]),
      .y_im (y_im[r*YW +: YW])
    );
  end

  fftst_butterfly #(
    .RADIX(RADIX), .IN_W(YW), .OUT_W(OUT_W), .DO_SCALE(DO_SCALE), .INVERSE(INVERSE)
  ) u_bf (
    .clk(clk), .rst_n(rst_n), .en(v1_q),
    .y_re(y_re), .y_im(y_im), .z_re(out_re), .z_im(out_im)
  );

  assign out_valid = v2_q;

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_re) && $stable(out_im)));

endmodule

// File: tb/tb_fft_radix_stage.sv
`timescale 1ns/1ps
module tb_fft_radix_stage;
  import fftst_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [63:0]  in_re16, in_im16;
  logic [103:0] in_re26, in_im26;

  logic vo [4];
  logic [71:0]  a_re, a_im, c_re, c_im;
  logic [63:0]  b_re, b_im;
  logic [103:0] d_re, d_im;

  always #5 clk = ~clk;

  // A: free growth, stage 1, forward
  fft_radix_stage #(.DATA_W(16), .STAGE_IDX(1), .GROWTH(GROW_FREE), .INVERSE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re16), .in_im(in_im16),
    .out_valid(vo[0]), .out_re(a_re), .out_im(a_im));
  // B: scale each, stage 1, inverse
  fft_radix_stage #(.DATA_W(16), .STAGE_IDX(1), .GROWTH(SCALE_EACH), .INVERSE(1'b1)) dut_sc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re16), .in_im(in_im16),
    .out_valid(vo[1]), .out_re(b_re), .out_im(b_im));
  // C: capped growth below the ceiling, stage 0
  fft_radix_stage #(.DATA_W(16), .STAGE_IDX(0), .GROWTH(GROW_CAPPED), .INVERSE(1'b0)) dut_cg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re16), .in_im(in_im16),
    .out_valid(vo[2]), .out_re(c_re), .out_im(c_im));
  // D: capped growth past the ceiling, stage 1
  fft_radix_stage #(.DATA_W(26), .STAGE_IDX(1), .GROWTH(GROW_CAPPED), .INVERSE(1'b0)) dut_cs (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re26), .in_im(in_im26),
    .out_valid(vo[3]), .out_re(d_re), .out_im(d_im));

  typedef struct {
    longint re [4];
    longint im [4];
    int     cyc;
  } exp_t;

  exp_t   q [4][$];
  longint last_re [4][4];
  longint last_im [4][4];
  bit     has_last [4];
  int     cyc = 0;
  int     g = 0;
  int     n_vec = 0;
  int     n_bad = 0;
  bit     done = 1'b0;
  longint xr [4];
  longint xi [4];

  localparam int    DW  [4] = '{16, 16, 16, 26};
  localparam int    OWV [4] = '{18, 16, 18, 26};
  localparam int    STG [4] = '{1, 1, 0, 1};
  localparam bit    INV [4] = '{1'b0, 1'b1, 1'b0, 1'b0};
  localparam bit    SCL [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam int    SHL [4] = '{0, 0, 0, 10};
  string tag [4] = '{"R2 R3 R4 R6 R9", "R5 R7 R9", "R8", "R8 R9"};

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint rq(real x, real s);
    if (x >= 0.0) return $rtoi(x * s + 0.5);
    else          return -$rtoi(-x * s + 0.5);
  endfunction

  function automatic longint sat(longint v, int w);
    longint hi, lo;
    hi = (64'sd1 <<< (w - 1)) - 1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint lane(logic [103:0] bus, int w, int k);
    longint v;
    v = longint'((bus >> (k * w)) & ((104'd1 << w) - 1));
    if (v >= (64'sd1 <<< (w - 1))) v = v - (64'sd1 <<< w);
    return v;
  endfunction

  // behavioural reference for one beat of configuration d
  function automatic exp_t model(int d, int beat);
    exp_t   o;
    longint yr [4];
    longint yi [4];
    real    pi2 = 2.0 * 3.14159265358979323846;
    for (int r = 0; r < 4; r++) begin
      int     span, stride, e;
      longint c, s, a, b;
      span   = 4 ** STG[d];
      stride = 16 / (4 ** (STG[d] + 1));
      e      = (r * (beat % span) * stride) % 16;
      c      = rq($cos(pi2 * e / 16.0), 65536.0);
      s      = rq($sin(pi2 * e / 16.0), 65536.0);
      if (!INV[d]) s = -s;
      a      = xr[r] <<< SHL[d];
      b      = xi[r] <<< SHL[d];
      yr[r]  = (a * c - b * s) >>> 16;
      yi[r]  = (a * s + b * c) >>> 16;
    end
    for (int k = 0; k < 4; k++) begin
      longint sr = 0, si = 0;
      for (int r = 0; r < 4; r++) begin
        longint kr, ki;
        kr = rq($cos(pi2 * r * k / 4.0), 1.0);
        ki = rq($sin(pi2 * r * k / 4.0), 1.0);
        if (!INV[d]) ki = -ki;
        sr = sr + yr[r] * kr - yi[r] * ki;
        si = si + yr[r] * ki + yi[r] * kr;
      end
      if (SCL[d]) begin sr = sr >>> 2; si = si >>> 2; end
      o.re[k] = sat(sr, OWV[d]);
      o.im[k] = sat(si, OWV[d]);
    end
    return o;
  endfunction

  task automatic check_one(int d, logic v, logic [103:0] br, logic [103:0] bi);
    longint ar, ai;
    bit bad;
    exp_t e;
    bad = 1'b0;
    if (v) begin
      n_vec++;
      if (q[d].size() == 0) begin
        $display("FAIL R1 dut%0d: out_valid=1 actual, expected 0 (no pending beat) cyc %0d", d, cyc);
        n_bad++;
        return;
      end
      e = q[d].pop_front();
      if (e.cyc != cyc) begin
        $display("FAIL R1 dut%0d: result in cycle %0d, expected cycle %0d", d, cyc, e.cyc);
        bad = 1'b1;
      end
      for (int k = 0; k < 4; k++) begin
        ar = lane(br, OWV[d], k);
        ai = lane(bi, OWV[d], k);
        if (ar != e.re[k] || ai != e.im[k]) begin
          $display("FAIL %s dut%0d lane %0d: actual (%0d,%0d) expected (%0d,%0d)",
                   tag[d], d, k, ar, ai, e.re[k], e.im[k]);
          bad = 1'b1;
        end
        last_re[d][k] = ar;
        last_im[d][k] = ai;
      end
      has_last[d] = 1'b1;
      if (bad) n_bad++;
    end else begin
      if (q[d].size() != 0 && q[d][0].cyc <= cyc) begin
        n_vec++;
        n_bad++;
        $display("FAIL R1 dut%0d: out_valid=0 actual, expected 1 in cycle %0d", d, cyc);
        void'(q[d].pop_front());
      end
      if (has_last[d]) begin
        n_vec++;
        for (int k = 0; k < 4; k++) begin
          ar = lane(br, OWV[d], k);
          ai = lane(bi, OWV[d], k);
          if (ar != last_re[d][k] || ai != last_im[d][k]) begin
            $display("FAIL R10 dut%0d lane %0d idle change: actual (%0d,%0d) expected (%0d,%0d)",
                     d, k, ar, ai, last_re[d][k], last_im[d][k]);
            bad = 1'b1;
          end
        end
        if (bad) n_bad++;
      end
    end
  endtask

  task automatic check_all();
    check_one(0, vo[0], {32'd0, a_re}, {32'd0, a_im});
    check_one(1, vo[1], {40'd0, b_re}, {40'd0, b_im});
    check_one(2, vo[2], {32'd0, c_re}, {32'd0, c_im});
    check_one(3, vo[3], d_re, d_im);
  endtask

  task automatic drive_bus();
    for (int r = 0; r < 4; r++) begin
      longint w = xr[r] <<< 10;
      longint z = xi[r] <<< 10;
      in_re16[r*16 +: 16] = xr[r][15:0];
      in_im16[r*16 +: 16] = xi[r][15:0];
      in_re26[r*26 +: 26] = w[25:0];
      in_im26[r*26 +: 26] = z[25:0];
    end
  endtask

  task automatic step(bit v);
    @(negedge clk);
    check_all();
    in_valid = v;
    drive_bus();
    if (v) begin
      for (int d = 0; d < 4; d++) begin
        exp_t e = model(d, g);
        e.cyc = cyc + 2;
        q[d].push_back(e);
      end
      g = (g + 1) % 4;
    end
  endtask

  task automatic set_all(longint re, longint im);
    for (int r = 0; r < 4; r++) begin xr[r] = re; xi[r] = im; end
  endtask

  task automatic set_rand();
    for (int r = 0; r < 4; r++) begin
      xr[r] = longint'($urandom % 65536) - 32768;
      xi[r] = longint'($urandom % 65536) - 32768;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_all();
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int d = 0; d < 4; d++) q[d].delete();
    g = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      n_vec++;
      // R11: out_valid held low during reset
      if (vo[0] | vo[1] | vo[2] | vo[3]) begin
        n_bad++;
        $display("FAIL R11 out_valid actual %b%b%b%b expected 0000", vo[0], vo[1], vo[2], vo[3]);
      end
    end
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    set_all(0, 0);
    drive_bus();
    do_reset();
    // impulse on lane 0, then on lane 2 (R4 lane order)
    set_all(0, 0); xr[0] = 1000;
    repeat (4) step(1'b1);
    set_all(0, 0); xr[2] = -700; xi[2] = 300;
    repeat (4) step(1'b1);
    // constant lanes
    set_all(3000, -2000);
    repeat (4) step(1'b1);
    // idle cycles with changing data must not count as beats (R10)
    for (int i = 0; i < 6; i++) begin set_rand(); step(1'b0); end
    set_all(0, 0); xr[1] = 12345; xi[3] = -4321;
    repeat (4) step(1'b1);
    // full-scale corners drive the clamp (R9)
    set_all(32767, 32767);
    repeat (4) step(1'b1);
    set_all(-32768, -32768);
    repeat (4) step(1'b1);
    for (int i = 0; i < 4; i++) begin
      for (int r = 0; r < 4; r++) begin
        xr[r] = (r % 2 == 0) ? 32767 : -32768;
        xi[r] = (r < 2) ? -32768 : 32767;
      end
      step(1'b1);
    end
    // reset in mid-frame clears the beat counter (R11)
    set_rand(); step(1'b1);
    set_rand(); step(1'b1);
    do_reset();
    set_all(0, 0); xr[3] = 5000; xi[1] = 5000;
    repeat (4) step(1'b1);
    // random traffic with gaps
    for (int i = 0; i < 400; i++) begin
      set_rand();
      step(($urandom % 4) != 0);
    end
    repeat (4) step(1'b0);
    for (int d = 0; d < 4; d++) begin
      n_vec++;
      if (q[d].size() != 0) begin
        n_bad++;
        $display("FAIL R1 dut%0d: %0d results outstanding, expected 0", d, q[d].size());
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end

endmodule